// File: doc/BRIEF.md
# Page Content Signature from Line Check Bits

This block forms a 32-bit signature of a memory page while the page's cache lines pass through the memory controller. For every line it either takes the check bits fetched alongside the data, or runs the line through the same SECDED encoder the write path uses. It then keeps the low check byte of four fixed line slots. No extra read pass is needed. A collision between different pages is tolerated, because software rechecks page contents before merging them.

Lines may arrive in any order. Each one carries its index within the page. A start pulse opens a page and discards any partial signature. An end pulse commits the signature to the candidate register, together with a flag that reports whether all four sampled slots were seen. The encoder output for the current line is also driven out for use by the normal data path.

Top module: `page_ecc_hash`

## Requirements
- R1: After reset, `cand_hash` is 0 and `cand_valid` is 0.
- R2: With `use_stored`=0, `line_ecc` carries one check byte per 64-bit word. Word k sits in `line_data[64k+63:64k]` and its check byte in `line_ecc[8k+7:8k]`. Data bit i takes the i-th position, counting from 3 upward, that is not a power of two. Check bit j (0..6) is the XOR of the data bits whose position has bit j set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6. Example: word 1 gives 0x83.
- R3: With `use_stored`=1, `line_ecc` equals `stored_ecc`.
- R4: The signature is {E(0), E(21), E(42), E(63)}, most significant byte first, where E(n) is `line_ecc[7:0]` of line index n.
- R5: The signature does not depend on the order in which lines arrive.
- R6: An end pulse after all four sampled lines were seen sets `cand_valid` to 1 and loads `cand_hash` on the next clock edge.
- R7: An end pulse while any sampled line is missing sets `cand_valid` to 0 and leaves `cand_hash` unchanged.
- R8: A start pulse clears `cand_valid` and forgets every sampled byte of the previous page.
- R9: Lines whose index is not a sampled slot have no effect on the signature.
- R10: A line presented in the same cycle as an end pulse is included in that page. A line presented in the same cycle as a start pulse counts toward the new page.
- R11: When a sampled index arrives twice in one page, the later byte is used.
- R12: `cand_hash` changes only on an end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_start | input | 1 | Opens a new page, one-cycle pulse |
| page_end | input | 1 | Commits the signature, one-cycle pulse |
| line_valid | input | 1 | A line is present this cycle |
| line_idx | input | 6 | Line index within the page |
| line_data | input | 512 | Line data, word 0 in the low bits |
| stored_ecc | input | 64 | Check bits read with the line |
| use_stored | input | 1 | 1: use stored_ecc, 0: use encoder output |
| line_ecc | output | 64 | Selected check bits of the current line |
| cand_hash | output | 32 | Committed page signature |
| cand_valid | output | 1 | Committed signature covers all four slots |

## Verification
A wrong seen-mask bit shows up at the next end pulse: either `cand_valid` takes the wrong value, or `cand_hash` loads when it should hold. A byte captured from the wrong slot, or kept across a start pulse, appears as a corrupted byte lane of `cand_hash` one cycle after the end pulse. Encoder faults show combinationally on `line_ecc` in the same cycle the line is driven, so they are caught before any page is committed.

// File: rtl/pgh_pkg.sv
package pgh_pkg;
   localparam int unsigned CODE_DATA_W = 64;
   localparam int unsigned CODE_CHK_W  = 8;
   localparam int unsigned NUM_TAPS    = 4;
   localparam int unsigned TAP_BYTE_W  = 8;
   localparam int unsigned SIG_W       = NUM_TAPS * TAP_BYTE_W;

   typedef logic [CODE_DATA_W-1:0] code_word_t;
   typedef logic [CODE_CHK_W-1:0]  code_chk_t;
   typedef logic [TAP_BYTE_W-1:0]  tap_byte_t;
   typedef logic [SIG_W-1:0]       sig_t;
endpackage

// File: rtl/pgh_secded_enc.sv
module pgh_secded_enc
   import pgh_pkg::*;
(
   input  code_word_t word_i,
   output code_chk_t  chk_o
);
   logic [6:0] syn;

   always_comb begin
      int unsigned d;
      syn = '0;
      d   = 0;
      for (int unsigned p = 3; p < 72; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (word_i[d[5:0]]) syn = syn ^ p[6:0];
            d = d + 1;
         end
      end
   end

   assign chk_o = {(^word_i) ^ (^syn), syn};
endmodule

// File: rtl/pgh_line_ecc.sv
module pgh_line_ecc
   import pgh_pkg::*;
#(
   parameter int unsigned WORDS_PER_LINE = 8,
   localparam int unsigned LINE_W = WORDS_PER_LINE * CODE_DATA_W,
   localparam int unsigned ECC_W  = WORDS_PER_LINE * CODE_CHK_W
)(
   input  logic [LINE_W-1:0] line_data_i,
   input  logic [ECC_W-1:0]  stored_ecc_i,
   input  logic              use_stored_i,
   output logic [ECC_W-1:0]  line_ecc_o
);
   logic [ECC_W-1:0] calc_ecc;

   for (genvar w = 0; w < WORDS_PER_LINE; w++) begin : g_word
      pgh_secded_enc u_enc (
         .word_i (line_data_i[w*CODE_DATA_W +: CODE_DATA_W]),
         .chk_o  (calc_ecc[w*CODE_CHK_W +: CODE_CHK_W])
      );
   end

   assign line_ecc_o = use_stored_i ? stored_ecc_i : calc_ecc;
endmodule

// File: rtl/pgh_tap_accum.sv
module pgh_tap_accum
   import pgh_pkg::*;
#(
   parameter int unsigned IDX_W = 6,
   parameter int unsigned TAP0  = 0,
   parameter int unsigned TAP1  = 21,
   parameter int unsigned TAP2  = 42,
   parameter int unsigned TAP3  = 63
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             line_valid_i,
   input  logic [IDX_W-1:0] line_idx_i,
   input  tap_byte_t        ecc_byte_i,
   output sig_t             sig_nxt_o,
   output logic             full_nxt_o
);
   localparam int unsigned TAPS [NUM_TAPS] = '{TAP0, TAP1, TAP2, TAP3};

   logic [NUM_TAPS-1:0] seen_q, seen_d;
   tap_byte_t           byte_q [NUM_TAPS];
   tap_byte_t           byte_d [NUM_TAPS];

   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      logic hit;
      assign hit = line_valid_i && (line_idx_i == IDX_W'(TAPS[t]));

      always_comb begin
         seen_d[t] = start_i ? 1'b0 : seen_q[t];
         byte_d[t] = start_i ? '0 : byte_q[t];
         if (hit) begin
            seen_d[t] = 1'b1;
            byte_d[t] = ecc_byte_i;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seen_q[t] <= 1'b0;
            byte_q[t] <= '0;
         end else begin
            seen_q[t] <= seen_d[t];
            byte_q[t] <= byte_d[t];
         end
      end

      // slot 0 lands in the top byte
      assign sig_nxt_o[(NUM_TAPS-1-t)*TAP_BYTE_W +: TAP_BYTE_W] = byte_d[t];
   end

   assign full_nxt_o = &seen_d;

   AST_START_CLEARS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !line_valid_i) |=> (seen_q == '0)); // R8
   AST_SEEN_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ((seen_q & $past(seen_q)) == $past(seen_q))); // R5
endmodule

// File: rtl/page_ecc_hash.sv
module page_ecc_hash
   import pgh_pkg::*;
#(
   parameter int unsigned LINES_PER_PAGE = 64,
   parameter int unsigned WORDS_PER_LINE = 8,
   parameter int unsigned TAP0 = 0,
   parameter int unsigned TAP1 = 21,
   parameter int unsigned TAP2 = 42,
   parameter int unsigned TAP3 = 63,
   localparam int unsigned IDX_W  = $clog2(LINES_PER_PAGE),
   localparam int unsigned LINE_W = WORDS_PER_LINE * CODE_DATA_W,
   localparam int unsigned ECC_W  = WORDS_PER_LINE * CODE_CHK_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_start,
   input  logic              page_end,
   input  logic              line_valid,
   input  logic [IDX_W-1:0]  line_idx,
   input  logic [LINE_W-1:0] line_data,
   input  logic [ECC_W-1:0]  stored_ecc,
   input  logic              use_stored,
   output logic [ECC_W-1:0]  line_ecc,
   output logic [SIG_W-1:0]  cand_hash,
   output logic              cand_valid
);
   if (LINES_PER_PAGE < 2) begin : g_bad_lines
      $error("LINES_PER_PAGE must be at least 2");
   end
   if (WORDS_PER_LINE < 1) begin : g_bad_words
      $error("WORDS_PER_LINE must be at least 1");
   end
   if (TAP0 >= LINES_PER_PAGE || TAP1 >= LINES_PER_PAGE ||
       TAP2 >= LINES_PER_PAGE || TAP3 >= LINES_PER_PAGE) begin : g_bad_tap
      $error("sampled line index outside the page");
   end
   if (TAP0 == TAP1 || TAP0 == TAP2 || TAP0 == TAP3 ||
       TAP1 == TAP2 || TAP1 == TAP3 || TAP2 == TAP3) begin : g_dup_tap
      $error("sampled line indices must differ");
   end

   sig_t sig_nxt;
   logic full_nxt;

   pgh_line_ecc #(.WORDS_PER_LINE(WORDS_PER_LINE)) u_line_ecc (
      .line_data_i  (line_data),
      .stored_ecc_i (stored_ecc),
      .use_stored_i (use_stored),
      .line_ecc_o   (line_ecc)
   );

   pgh_tap_accum #(
      .IDX_W(IDX_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
   ) u_accum (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (page_start),
      .line_valid_i (line_valid),
      .line_idx_i   (line_idx),
      .ecc_byte_i   (line_ecc[TAP_BYTE_W-1:0]),
      .sig_nxt_o    (sig_nxt),
      .full_nxt_o   (full_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_hash  <= '0;
         cand_valid <= 1'b0;
      end else if (page_end) begin
         cand_valid <= full_nxt;
         if (full_nxt) cand_hash <= sig_nxt;
      end else if (page_start) begin
         cand_valid <= 1'b0;
      end
   end

   AST_VALID_ONLY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cand_valid) |-> $past(page_end)); // R6
   AST_HASH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !page_end |=> $stable(cand_hash)); // R12
   AST_VALID_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cand_valid) |-> $past(page_start || page_end)); // R8
endmodule

// File: tb/test_page_ecc_hash.sv
module test_page_ecc_hash;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         page_start = 1'b0;
   logic         page_end = 1'b0;
   logic         line_valid = 1'b0;
   logic [5:0]   line_idx = '0;
   logic [511:0] line_data = '0;
   logic [63:0]  stored_ecc = '0;
   logic         use_stored = 1'b0;
   logic [63:0]  line_ecc;
   logic [31:0]  cand_hash;
   logic         cand_valid;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   page_ecc_hash i_page_ecc_hash (
      .clk(clk), .rst_n(rst_n), .page_start(page_start), .page_end(page_end),
      .line_valid(line_valid), .line_idx(line_idx), .line_data(line_data),
      .stored_ecc(stored_ecc), .use_stored(use_stored), .line_ecc(line_ecc),
      .cand_hash(cand_hash), .cand_valid(cand_valid)
   );

   function automatic logic [7:0] ref_chk(logic [63:0] w);
      int pos [64];
      int n = 0;
      logic [7:0] c = '0;
      for (int p = 3; p < 72; p++)
         if (p != 4 && p != 8 && p != 16 && p != 32 && p != 64) begin
            pos[n] = p;
            n++;
         end
      for (int j = 0; j < 7; j++)
         for (int k = 0; k < 64; k++)
            if (((pos[k] >> j) & 1) == 1) c[j] = c[j] ^ w[k];
      c[7] = (^w) ^ (^c[6:0]);
      return c;
   endfunction

   function automatic logic [511:0] mk_line(logic [31:0] seed);
      logic [511:0] v;
      for (int i = 0; i < 16; i++) v[i*32 +: 32] = seed * 32'h9E3779B1 + i * 32'h01000193;
      return v;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drives one line for one cycle; returns the byte it should contribute
   task automatic send(input logic [5:0] idx, input logic [31:0] seed,
                       input logic use_st, input logic st, input logic en,
                       output logic [7:0] b);
      @(negedge clk);
      line_valid = 1'b1; line_idx = idx; line_data = mk_line(seed);
      stored_ecc = {seed, ~seed}; use_stored = use_st;
      page_start = st; page_end = en;
      b = use_st ? stored_ecc[7:0] : ref_chk(line_data[63:0]);
      @(negedge clk);
      line_valid = 1'b0; page_start = 1'b0; page_end = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); page_start = 1'b1;
      @(negedge clk); page_start = 1'b0;
   endtask

   task automatic pulse_end();
      @(negedge clk); page_end = 1'b1;
      @(negedge clk); page_end = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 hash after reset", 64'(cand_hash), 64'h0);
      check("R1 valid after reset", 64'(cand_valid), 64'h0);
   endtask

   task automatic t_encoder();
      logic [63:0] exp;
      @(negedge clk);
      use_stored = 1'b0; line_data = '0; line_data[63:0] = 64'h1;
      #1 check("R2 word value 1", 64'(line_ecc[7:0]), 64'h83);
      line_data = '0;
      #1 check("R2 zero line", line_ecc, 64'h0);
      line_data = mk_line(32'h55);
      for (int w = 0; w < 8; w++) exp[w*8 +: 8] = ref_chk(line_data[w*64 +: 64]);
      #1 check("R2 all words", line_ecc, exp);
   endtask

   task automatic t_stored();
      @(negedge clk);
      use_stored = 1'b1; stored_ecc = 64'hDEAD_BEEF_0123_4567; line_data = mk_line(32'h9);
      #1 check("R3 stored bits selected", line_ecc, 64'hDEAD_BEEF_0123_4567);
      use_stored = 1'b0;
   endtask

   task automatic t_basic(output logic [31:0] h);
      logic [7:0] b0, b1, b2, b3;
      pulse_start();
      send(6'd0, 32'h11, 1'b0, 1'b0, 1'b0, b0);
      send(6'd21, 32'h22, 1'b0, 1'b0, 1'b0, b1);
      send(6'd42, 32'h33, 1'b0, 1'b0, 1'b0, b2);
      send(6'd63, 32'h44, 1'b0, 1'b0, 1'b0, b3);
      check("R6 valid not before end", 64'(cand_valid), 64'h0);
      pulse_end();
      h = {b0, b1, b2, b3};
      check("R6 valid after end", 64'(cand_valid), 64'h1);
      check("R4 byte layout", 64'(cand_hash), 64'(h));
   endtask

   task automatic t_order(input logic [31:0] h_ref);
      logic [7:0] b0, b1, b2, b3, bx;
      pulse_start();
      send(6'd63, 32'h44, 1'b0, 1'b0, 1'b0, b3);
      send(6'd5, 32'h77, 1'b0, 1'b0, 1'b0, bx);
      send(6'd42, 32'h33, 1'b0, 1'b0, 1'b0, b2);
      send(6'd0, 32'h11, 1'b0, 1'b0, 1'b0, b0);
      send(6'd62, 32'h78, 1'b1, 1'b0, 1'b0, bx);
      send(6'd21, 32'h22, 1'b0, 1'b0, 1'b0, b1);
      pulse_end();
      check("R5 reversed order same signature", 64'(cand_hash), 64'(h_ref));
      check("R9 other lines ignored", 64'(cand_hash), 64'({b0, b1, b2, b3}));
   endtask

   task automatic t_mixed(output logic [31:0] h);
      logic [7:0] b0, b1, b2, b3;
      pulse_start();
      send(6'd21, 32'hA1, 1'b1, 1'b0, 1'b0, b1);
      send(6'd0, 32'hA2, 1'b0, 1'b0, 1'b0, b0);
      send(6'd42, 32'hA3, 1'b1, 1'b0, 1'b0, b2);
      send(6'd63, 32'hA4, 1'b0, 1'b0, 1'b0, b3);
      pulse_end();
      h = {b0, b1, b2, b3};
      check("R3 stored bytes in signature", 64'(cand_hash), 64'(h));
      repeat (4) @(negedge clk);
      check("R12 held while idle", 64'(cand_hash), 64'(h));
   endtask

   task automatic t_missing(input logic [31:0] h_prev);
      logic [7:0] b;
      pulse_start();
      check("R8 start clears valid", 64'(cand_valid), 64'h0);
      send(6'd0, 32'hB1, 1'b0, 1'b0, 1'b0, b);
      send(6'd21, 32'hB2, 1'b0, 1'b0, 1'b0, b);
      send(6'd63, 32'hB3, 1'b0, 1'b0, 1'b0, b);
      pulse_end();
      check("R7 R8 incomplete page invalid", 64'(cand_valid), 64'h0);
      check("R7 hash kept", 64'(cand_hash), 64'(h_prev));
   endtask

   task automatic t_same_cycle();
      logic [7:0] b0, b1, b2, b3, bx;
      pulse_start();
      send(6'd42, 32'hC0, 1'b0, 1'b0, 1'b0, bx);
      // line 0 arrives with the next start: the old line 42 must be forgotten
      send(6'd0, 32'hC1, 1'b0, 1'b1, 1'b0, b0);
      send(6'd21, 32'hC2, 1'b0, 1'b0, 1'b0, b1);
      send(6'd63, 32'hC4, 1'b0, 1'b0, 1'b1, b3);
      check("R10 R8 stale slot not reused", 64'(cand_valid), 64'h0);
      pulse_start();
      send(6'd0, 32'hD1, 1'b0, 1'b1, 1'b0, b0);
      send(6'd21, 32'hD2, 1'b0, 1'b0, 1'b0, b1);
      send(6'd42, 32'hD3, 1'b0, 1'b0, 1'b0, b2);
      send(6'd63, 32'hD4, 1'b1, 1'b0, 1'b1, b3);
      check("R10 line with end included", 64'(cand_valid), 64'h1);
      check("R10 signature", 64'(cand_hash), 64'({b0, b1, b2, b3}));
   endtask

   task automatic t_repeat();
      logic [7:0] b0, b1, b2, b3;
      pulse_start();
      send(6'd0, 32'hE1, 1'b0, 1'b0, 1'b0, b0);
      send(6'd21, 32'hE2, 1'b0, 1'b0, 1'b0, b1);
      send(6'd42, 32'hE3, 1'b0, 1'b0, 1'b0, b2);
      send(6'd21, 32'hE9, 1'b1, 1'b0, 1'b0, b1);
      send(6'd63, 32'hE4, 1'b0, 1'b0, 1'b0, b3);
      pulse_end();
      check("R11 later duplicate wins", 64'(cand_hash), 64'({b0, b1, b2, b3}));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] h1, h2;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_encoder();
      t_stored();
      t_basic(h1);
      t_order(h1);
      t_mixed(h2);
      t_missing(h2);
      t_same_cycle();
      t_repeat();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule